// File: doc/BRIEF.md
# Rotating Register Window Controller

This block holds a physical register file whose size is a power of two and a multiple of four, and presents sixteen logical registers through a window that starts at physical register `4 * base` and wraps past the last physical register to register 0. It owns the window base, a per-window "frame live" bitmap, and a small status set: overflow-trap enable, exception mode, call increment and saved base.

A decoder drives one operation per cycle on the `op_*` inputs. The operations are function entry, windowed return, signed rotate, base write, base restore from the saved field, overflow probe, stack-pointer-move probe, status write and bitmap write. When an operation cannot finish normally, the block raises a one-cycle exception request. The request gives a spill size (4, 8 or 12 registers), a fill size, an illegal-instruction code or an alloca code, and it records the faulting PC. A legal return that needs no fill instead produces a one-cycle return-target strobe. A separate write port and read port reach the logical registers at the current base.

Top module: `win_regfile_ctrl`

## Requirements
- R1: After reset the base is 0, the bitmap holds only bit 0, every status field is 0, and neither `exc_valid` nor `ret_valid` is high.
- R2: The logical register i reads and writes physical register (4*base + i) mod NPHYS, for the read port, the write port and the entry write.
- R3: The base is always reduced modulo NPHYS/4. Rotate (op 3) adds the sign-extended `op_arg[3:0]`. Base write (op 4) loads `op_arg` mod NPHYS/4. Restore (op 5) loads the saved-base field.
- R4: Entry (op 1) raises illegal (kind 7) when `op_sreg` > 3, or when the enable bit is clear, or when exception mode is set. State does not change.
- R5: A legal entry writes `L[s] - op_arg*8` into logical register callinc*4+s of the old window. It then adds callinc to the base and sets the bitmap bit of the new base.
- R6: The overflow probe (op 6, width `op_arg[1:0]`) does nothing when the enable bit is clear, when exception mode is set, or when no bitmap bit is set at base+1 .. base+width.
- R7: When the probe finds its first set bit at offset n, the base moves by n, the old base goes to the saved field, exception mode is set and the PC is recorded. With m = old base + n, the kind is 1 (spill 4) if bit m+1 is set, otherwise 2 (spill 8) if bit m+2 is set, otherwise 3 (spill 12).
- R8: Return (op 2) takes n from bits 31:30 of logical register 0, and m as the first of base-1, base-2, base-3 whose bit is set (1, 2, 3, or 0 if none). It raises illegal when n = 0, when m is nonzero and differs from n, or when the enable/exception-mode condition fails.
- R9: A legal return moves the base back by n. If the bit at the new base is set, it clears the bit of the old base and pulses `ret_valid` with `ret_pc` = {PC[31:30], L0[29:0]}.
- R10: If the bit at the new base is clear after a legal return, the block saves the old base, sets exception mode, records the PC and requests a fill of kind 4, 5 or 6 for n = 1, 2 or 3. `ret_valid` stays low.
- R11: The stack-pointer-move probe (op 7) raises alloca (kind 8) exactly when the bits at base-1, base-2 and base-3 are all clear.
- R12: Status write (op 8) loads enable = `op_arg[0]`, exception mode = `op_arg[1]`, callinc = `op_arg[3:2]` and saved base = `op_arg[4 +: BW]`. Bitmap write (op 9) loads `op_arg[NWIN-1:0]`. Results show on the edge that accepts the op. `exc_valid` is high for one cycle per faulting op.
- R13: In a cycle where a legal entry writes the file, the write port is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation selector (0 idle, 1..9 as in the requirements) |
| op_arg | input | DW | Immediate, rotate amount, base, width, status or bitmap value |
| op_sreg | input | 4 | Stack register index for entry |
| op_pc | input | 32 | PC of the operation |
| wr_en | input | 1 | Logical register write enable |
| wr_idx | input | 4 | Logical register written |
| wr_data | input | DW | Write data |
| rd_idx | input | 4 | Logical register read |
| rd_data | output | DW | Read data (combinational) |
| win_base | output | BW | Current window base |
| win_start | output | NWIN | Frame-live bitmap |
| st_woe | output | 1 | Overflow-trap enable |
| st_excm | output | 1 | Exception mode |
| st_callinc | output | 2 | Call increment |
| st_owb | output | BW | Saved base |
| exc_valid | output | 1 | Exception request pulse |
| exc_kind | output | 4 | Exception kind (0 none, 1-3 spill, 4-6 fill, 7 illegal, 8 alloca) |
| exc_pc | output | 32 | PC recorded at the last exception |
| ret_valid | output | 1 | Return-target pulse |
| ret_pc | output | 32 | Return target |

## Verification
The properties assume that `op_code` carries only values 0 to 9 while `op_valid` is high. They also assume that the physical file was written before any register that feeds a return or an entry is read, because the file has no reset. The stimulus writes every register it later reads and drives only the defined operation codes. It changes inputs only between clock edges, one operation at a time. Bitmap and status values are set explicitly before each probe, so every overflow, underflow and alloca outcome starts from a known state.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_ENTRY   = 4'd1,
    OP_RETW    = 4'd2,
    OP_ROTW    = 4'd3,
    OP_WBASE   = 4'd4,
    OP_RESTORE = 4'd5,
    OP_OVCHK   = 4'd6,
    OP_MOVSP   = 4'd7,
    OP_SETST   = 4'd8,
    OP_SETWS   = 4'd9
  } wrf_op_e;

  typedef enum logic [3:0] {
    EX_NONE    = 4'd0,
    EX_OVF4    = 4'd1,
    EX_OVF8    = 4'd2,
    EX_OVF12   = 4'd3,
    EX_UNF4    = 4'd4,
    EX_UNF8    = 4'd5,
    EX_UNF12   = 4'd6,
    EX_ILLEGAL = 4'd7,
    EX_ALLOCA  = 4'd8
  } wrf_exc_e;

endpackage

// File: rtl/wrf_phys_file.sv
module wrf_phys_file #(
  parameter int NPHYS = 64,
  parameter int DW    = 32,
  parameter int NRD   = 3,
  localparam int BW   = $clog2(NPHYS / 4),
  localparam int PA   = $clog2(NPHYS)
) (
  input  logic                    clk,
  input  logic [BW-1:0]           base,
  input  logic                    we,
  input  logic [3:0]              widx,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][3:0]     ridx,
  output logic [NRD-1:0][DW-1:0]  rdata
);

  logic [DW-1:0] mem [NPHYS];
  logic [PA-1:0] waddr;

  function automatic logic [PA-1:0] phys_of(input logic [BW-1:0] b, input logic [3:0] i);
    phys_of = (PA'(b) << 2) + PA'(i);
  endfunction

  assign waddr = phys_of(base, widx);

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[phys_of(base, ridx[p])];
  end

endmodule

// File: rtl/wrf_window_scan.sv
module wrf_window_scan import wrf_pkg::*; #(
  parameter int NWIN = 16,
  localparam int BW  = $clog2(NWIN)
) (
  input  logic [BW-1:0]   base,
  input  logic [NWIN-1:0] ws,
  input  logic [1:0]      chk_w,
  output logic            ovf_hit,
  output logic [1:0]      ovf_n,
  output wrf_exc_e        ovf_kind,
  output logic [1:0]      prev_m
);

  logic [5:1] up;
  logic [3:1] dn;
  logic       nb1, nb2;

  for (genvar k = 1; k <= 5; k++) begin : g_up
    assign up[k] = ws[base + BW'(k)];
  end
  for (genvar k = 1; k <= 3; k++) begin : g_dn
    assign dn[k] = ws[base - BW'(k)];
  end

  always_comb begin
    ovf_hit = 1'b0;
    ovf_n   = 2'd0;
    if (chk_w >= 2'd1 && up[1]) begin
      ovf_hit = 1'b1;
      ovf_n   = 2'd1;
    end else if (chk_w >= 2'd2 && up[2]) begin
      ovf_hit = 1'b1;
      ovf_n   = 2'd2;
    end else if (chk_w == 2'd3 && up[3]) begin
      ovf_hit = 1'b1;
      ovf_n   = 2'd3;
    end
  end

  always_comb begin
    case (ovf_n)
      2'd1:    begin nb1 = up[2]; nb2 = up[3]; end
      2'd2:    begin nb1 = up[3]; nb2 = up[4]; end
      default: begin nb1 = up[4]; nb2 = up[5]; end
    endcase
    ovf_kind = nb1 ? EX_OVF4 : (nb2 ? EX_OVF8 : EX_OVF12);
  end

  always_comb begin
    if (dn[1])      prev_m = 2'd1;
    else if (dn[2]) prev_m = 2'd2;
    else if (dn[3]) prev_m = 2'd3;
    else            prev_m = 2'd0;
  end

endmodule

// File: rtl/win_regfile_ctrl.sv
module win_regfile_ctrl import wrf_pkg::*; #(
  parameter int NPHYS  = 64,
  parameter int DW     = 32,
  localparam int NWIN  = NPHYS / 4,
  localparam int BW    = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [3:0]      op_code,
  input  logic [DW-1:0]   op_arg,
  input  logic [3:0]      op_sreg,
  input  logic [31:0]     op_pc,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic [3:0]      rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic [BW-1:0]   win_base,
  output logic [NWIN-1:0] win_start,
  output logic            st_woe,
  output logic            st_excm,
  output logic [1:0]      st_callinc,
  output logic [BW-1:0]   st_owb,
  output logic            exc_valid,
  output logic [3:0]      exc_kind,
  output logic [31:0]     exc_pc,
  output logic            ret_valid,
  output logic [31:0]     ret_pc
);

  // architectural state
  logic [BW-1:0]   base_q, base_d;
  logic [NWIN-1:0] ws_q, ws_d;
  logic            woe_q, woe_d, excm_q, excm_d;
  logic [1:0]      cinc_q, cinc_d;
  logic [BW-1:0]   owb_q, owb_d;
  wrf_exc_e        exc_q, exc_d;
  logic [31:0]     epc_q, epc_d;
  logic            retv_q, retv_d;
  logic [31:0]     retpc_q, retpc_d;
  logic            state_en;

  // register file hookup
  logic [2:0][3:0]    ridx;
  logic [2:0][DW-1:0] rdata;
  logic               ent_we, rf_we;
  logic [3:0]         rf_widx;
  logic [DW-1:0]      rf_wdata;
  logic [DW-1:0]      reg0;
  logic [1:0]         ret_n;

  // scan results
  logic     ovf_hit;
  logic [1:0] ovf_n, prev_m;
  wrf_exc_e ovf_kind;
  logic     wnd_ok;
  logic [BW-1:0] nb;

  assign ridx[0] = rd_idx;
  assign ridx[1] = op_sreg;
  assign ridx[2] = 4'd0;
  assign reg0    = rdata[2];
  assign ret_n   = reg0[31:30];
  assign wnd_ok  = woe_q & ~excm_q;

  wrf_phys_file #(.NPHYS(NPHYS), .DW(DW), .NRD(3)) u_file (
    .clk   (clk),
    .base  (base_q),
    .we    (rf_we),
    .widx  (rf_widx),
    .wdata (rf_wdata),
    .ridx  (ridx),
    .rdata (rdata)
  );

  wrf_window_scan #(.NWIN(NWIN)) u_scan (
    .base     (base_q),
    .ws       (ws_q),
    .chk_w    (op_arg[1:0]),
    .ovf_hit  (ovf_hit),
    .ovf_n    (ovf_n),
    .ovf_kind (ovf_kind),
    .prev_m   (prev_m)
  );

  // entry write takes the single write port over the external one
  assign rf_we    = ent_we | wr_en;
  assign rf_widx  = ent_we ? {cinc_q, op_sreg[1:0]} : wr_idx;
  assign rf_wdata = ent_we ? (rdata[1] - (op_arg << 3)) : wr_data;

  // next-state logic
  always_comb begin
    base_d  = base_q;
    ws_d    = ws_q;
    woe_d   = woe_q;
    excm_d  = excm_q;
    cinc_d  = cinc_q;
    owb_d   = owb_q;
    exc_d   = EX_NONE;
    epc_d   = epc_q;
    retv_d  = 1'b0;
    retpc_d = retpc_q;
    ent_we  = 1'b0;
    nb      = base_q;
    if (op_valid) begin
      case (op_code)
        OP_ENTRY: begin
          if (op_sreg > 4'd3 || !wnd_ok) begin
            exc_d = EX_ILLEGAL;
            epc_d = op_pc;
          end else begin
            ent_we     = 1'b1;
            nb         = base_q + BW'(cinc_q);
            base_d     = nb;
            ws_d[nb]   = 1'b1;
          end
        end
        OP_RETW: begin
          if (ret_n == 2'd0 || (prev_m != 2'd0 && prev_m != ret_n) || !wnd_ok) begin
            exc_d = EX_ILLEGAL;
            epc_d = op_pc;
          end else begin
            nb     = base_q - BW'(ret_n);
            base_d = nb;
            if (ws_q[nb]) begin
              ws_d[base_q] = 1'b0;
              retv_d       = 1'b1;
              retpc_d      = {op_pc[31:30], reg0[29:0]};
            end else begin
              owb_d  = base_q;
              excm_d = 1'b1;
              epc_d  = op_pc;
              case (ret_n)
                2'd1:    exc_d = EX_UNF4;
                2'd2:    exc_d = EX_UNF8;
                default: exc_d = EX_UNF12;
              endcase
            end
          end
        end
        OP_ROTW:    base_d = base_q + BW'(signed'(op_arg[3:0]));
        OP_WBASE:   base_d = op_arg[BW-1:0];
        OP_RESTORE: base_d = owb_q;
        OP_OVCHK: begin
          if (wnd_ok && ovf_hit) begin
            base_d = base_q + BW'(ovf_n);
            owb_d  = base_q;
            excm_d = 1'b1;
            epc_d  = op_pc;
            exc_d  = ovf_kind;
          end
        end
        OP_MOVSP: begin
          if (prev_m == 2'd0) begin
            exc_d = EX_ALLOCA;
            epc_d = op_pc;
          end
        end
        OP_SETST: begin
          woe_d  = op_arg[0];
          excm_d = op_arg[1];
          cinc_d = op_arg[3:2];
          owb_d  = op_arg[4 +: BW];
        end
        OP_SETWS:   ws_d = op_arg[NWIN-1:0];
        default: ;
      endcase
    end
  end

  assign state_en = op_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      ws_q    <= NWIN'(1);
      woe_q   <= 1'b0;
      excm_q  <= 1'b0;
      cinc_q  <= 2'd0;
      owb_q   <= '0;
      epc_q   <= '0;
      retpc_q <= '0;
      exc_q   <= EX_NONE;
      retv_q  <= 1'b0;
    end else begin
      exc_q  <= exc_d;
      retv_q <= retv_d;
      if (state_en) begin
        base_q  <= base_d;
        ws_q    <= ws_d;
        woe_q   <= woe_d;
        excm_q  <= excm_d;
        cinc_q  <= cinc_d;
        owb_q   <= owb_d;
        epc_q   <= epc_d;
        retpc_q <= retpc_d;
      end
    end
  end

  assign rd_data    = rdata[0];
  assign win_base   = base_q;
  assign win_start  = ws_q;
  assign st_woe     = woe_q;
  assign st_excm    = excm_q;
  assign st_callinc = cinc_q;
  assign st_owb     = owb_q;
  assign exc_valid  = (exc_q != EX_NONE);
  assign exc_kind   = exc_q;
  assign exc_pc     = epc_q;
  assign ret_valid  = retv_q;
  assign ret_pc     = retpc_q;

  // R5
  entry_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ENTRY && op_sreg <= 4'd3 && st_woe && !st_excm)
    |=> (win_start[win_base] && win_base == $past(win_base + BW'(st_callinc))));

  // R7
  spill_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_kind >= 4'd1 && exc_kind <= 4'd3)
    |-> (st_excm && st_owb == $past(win_base)));

  // R8
  ret_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_RETW && ret_n == 2'd0)
    |=> (exc_kind == 4'd7 && !ret_valid));

  // R9
  ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (ret_pc[31:30] == $past(op_pc[31:30]) && !exc_valid));

  // R11
  alloca_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_MOVSP && prev_m == 2'd0) |=> (exc_kind == 4'd8));

  // R12
  exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $past(op_valid));

endmodule

// File: tb/sim_win_regfile_ctrl.sv
module sim_win_regfile_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [31:0] op_arg = '0;
  logic [3:0]  op_sreg = '0;
  logic [31:0] op_pc = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [3:0]  win_base;
  logic [15:0] win_start;
  logic        st_woe, st_excm;
  logic [1:0]  st_callinc;
  logic [3:0]  st_owb;
  logic        exc_valid;
  logic [3:0]  exc_kind;
  logic [31:0] exc_pc;
  logic        ret_valid;
  logic [31:0] ret_pc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  win_regfile_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_arg(op_arg), .op_sreg(op_sreg), .op_pc(op_pc), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .win_base(win_base), .win_start(win_start), .st_woe(st_woe),
    .st_excm(st_excm), .st_callinc(st_callinc), .st_owb(st_owb),
    .exc_valid(exc_valid), .exc_kind(exc_kind), .exc_pc(exc_pc),
    .ret_valid(ret_valid), .ret_pc(ret_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [31:0] arg, input logic [3:0] s,
                      input logic [31:0] pc, input logic we, input logic [3:0] wi,
                      input logic [31:0] wd);
    @(negedge clk);
    op_valid = (op != 4'd0);
    op_code  = op;
    op_arg   = arg;
    op_sreg  = s;
    op_pc    = pc;
    wr_en    = we;
    wr_idx   = wi;
    wr_data  = wd;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    wr_en    = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] i, input logic [31:0] d);
    step(4'd0, 32'd0, 4'd0, 32'd0, 1'b1, i, d);
  endtask

  task automatic rreg(input string req, input logic [3:0] i, input logic [31:0] exp);
    rd_idx = i;
    #1;
    check(req, rd_data, exp);
  endtask

  // fields: op[52:49] arg[48:17] sreg[16:13] kind[12:9] base[8:5] excm[4] req[3:0]
  localparam int NV = 33;
  localparam logic [52:0] TBL [NV] = '{
    {4'd3, 32'h5,    4'd0, 4'd0, 4'd5,  1'b0, 4'd3},  // R3 rotate +5
    {4'd3, 32'hE,    4'd0, 4'd0, 4'd3,  1'b0, 4'd3},  // R3 rotate -2
    {4'd3, 32'hD,    4'd0, 4'd0, 4'd0,  1'b0, 4'd3},  // R3 rotate -3
    {4'd3, 32'hF,    4'd0, 4'd0, 4'd15, 1'b0, 4'd3},  // R3 wrap below zero
    {4'd4, 32'h25,   4'd0, 4'd0, 4'd5,  1'b0, 4'd3},  // R3 base write modulo
    {4'd1, 32'h0,    4'd0, 4'd7, 4'd5,  1'b0, 4'd4},  // R4 enable clear
    {4'd8, 32'h39,   4'd0, 4'd0, 4'd5,  1'b0, 4'd12}, // R12 status write
    {4'd1, 32'h0,    4'd4, 4'd7, 4'd5,  1'b0, 4'd4},  // R4 s > 3
    {4'd5, 32'h0,    4'd0, 4'd0, 4'd3,  1'b0, 4'd3},  // R3 restore
    {4'd9, 32'h8,    4'd0, 4'd0, 4'd3,  1'b0, 4'd12}, // R12 bitmap write
    {4'd1, 32'h2,    4'd1, 4'd0, 4'd5,  1'b0, 4'd5},  // R5 callinc 2
    {4'd7, 32'h0,    4'd0, 4'd0, 4'd5,  1'b0, 4'd11}, // R11 bit 3 set
    {4'd6, 32'h3,    4'd0, 4'd0, 4'd5,  1'b0, 4'd6},  // R6 no bit above
    {4'd9, 32'h1A0,  4'd0, 4'd0, 4'd5,  1'b0, 4'd12},
    {4'd6, 32'h3,    4'd0, 4'd1, 4'd7,  1'b1, 4'd7},  // R7 spill 4
    {4'd6, 32'h3,    4'd0, 4'd0, 4'd7,  1'b1, 4'd6},  // R6 exception mode
    {4'd8, 32'h39,   4'd0, 4'd0, 4'd7,  1'b0, 4'd12},
    {4'd5, 32'h0,    4'd0, 4'd0, 4'd3,  1'b0, 4'd3},
    {4'd9, 32'h58,   4'd0, 4'd0, 4'd3,  1'b0, 4'd12},
    {4'd6, 32'h1,    4'd0, 4'd2, 4'd4,  1'b1, 4'd7},  // R7 spill 8
    {4'd8, 32'h39,   4'd0, 4'd0, 4'd4,  1'b0, 4'd12},
    {4'd9, 32'h50,   4'd0, 4'd0, 4'd4,  1'b0, 4'd12},
    {4'd6, 32'h1,    4'd0, 4'd0, 4'd4,  1'b0, 4'd6},  // R6 width too small
    {4'd6, 32'h2,    4'd0, 4'd3, 4'd6,  1'b1, 4'd7},  // R7 spill 12
    {4'd8, 32'h39,   4'd0, 4'd0, 4'd6,  1'b0, 4'd12},
    {4'd7, 32'h0,    4'd0, 4'd0, 4'd6,  1'b0, 4'd11},
    {4'd9, 32'h40,   4'd0, 4'd0, 4'd6,  1'b0, 4'd12},
    {4'd7, 32'h0,    4'd0, 4'd8, 4'd6,  1'b0, 4'd11}, // R11 alloca
    {4'd4, 32'hF,    4'd0, 4'd0, 4'd15, 1'b0, 4'd3},
    {4'd9, 32'h8003, 4'd0, 4'd0, 4'd15, 1'b0, 4'd12},
    {4'd6, 32'h1,    4'd0, 4'd1, 4'd0,  1'b1, 4'd7},  // R7 wrap to 0
    {4'd1, 32'h0,    4'd0, 4'd7, 4'd0,  1'b1, 4'd4},  // R4 exception mode
    {4'd8, 32'h39,   4'd0, 4'd0, 4'd0,  1'b0, 4'd12}
  };

  initial begin
    #9;
    // R1 reset state
    check("R1 base", {28'd0, win_base}, 32'd0);
    check("R1 bitmap", {16'd0, win_start}, 32'h1);
    check("R1 status", {26'd0, st_woe, st_excm, st_callinc, st_owb}, 32'd0);
    check("R1 pulses", {30'd0, exc_valid, ret_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [52:0] e;
      string tag;
      e = TBL[v];
      step(e[52:49], e[48:17], e[16:13], 32'h100 + 32'(v), 1'b0, 4'd0, 32'd0);
      tag = $sformatf("R%0d row%0d", e[3:0], v);
      check({tag, " kind"}, {28'd0, exc_kind}, {28'd0, e[12:9]});
      check({tag, " valid"}, {31'd0, exc_valid}, {31'd0, (e[12:9] != 4'd0)});
      check({tag, " base"}, {28'd0, win_base}, {28'd0, e[8:5]});
      check({tag, " excm"}, {31'd0, st_excm}, {31'd0, e[4]});
    end

    // R2 mapping and wrap
    step(4'd4, 32'hF, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0);
    wreg(4'd4, 32'hA4);
    wreg(4'd5, 32'hA5);
    step(4'd4, 32'h0, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0);
    rreg("R2 wrap l0", 4'd0, 32'hA4);
    rreg("R2 wrap l1", 4'd1, 32'hA5);
    step(4'd4, 32'hE, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0);
    rreg("R2 wrap l8", 4'd8, 32'hA4);

    // R5 entry data and R13 write-port drop
    step(4'd4, 32'h3, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0);
    step(4'd8, 32'h5, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0);
    step(4'd9, 32'h8, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0);
    wreg(4'd2, 32'd1000);
    wreg(4'd4, 32'h1111);
    wreg(4'd0, 32'h2222);
    step(4'd1, 32'd5, 4'd2, 32'h200, 1'b1, 4'd0, 32'hDEAD);
    check("R5 base", {28'd0, win_base}, 32'd4);
    check("R5 bitmap", {16'd0, win_start}, 32'h18);
    check("R5 no exc", {31'd0, exc_valid}, 32'd0);
    rreg("R5 entry data", 4'd2, 32'd960);
    rreg("R13 l0 new", 4'd0, 32'h1111);

    // R9 valid return
    wreg(4'd0, 32'h4000_1234);
    step(4'd2, 32'd0, 4'd0, 32'hC000_0100, 1'b0, 4'd0, 32'd0);
    check("R9 ret_valid", {31'd0, ret_valid}, 32'd1);
    check("R9 ret_pc", ret_pc, 32'hC000_1234);
    check("R9 base", {28'd0, win_base}, 32'd3);
    check("R9 bitmap", {16'd0, win_start}, 32'h8);
    rreg("R13 dropped write", 4'd0, 32'h2222);

    // R8 illegal returns
    wreg(4'd0, 32'h10);
    step(4'd2, 32'd0, 4'd0, 32'h300, 1'b0, 4'd0, 32'd0);
    check("R8 n zero", {28'd0, exc_kind}, 32'd7);
    check("R8 n zero base", {28'd0, win_base}, 32'd3);
    check("R8 no ret", {31'd0, ret_valid}, 32'd0);
    step(4'd9, 32'h2, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0);
    wreg(4'd0, 32'h4000_0000);
    step(4'd2, 32'd0, 4'd0, 32'h304, 1'b0, 4'd0, 32'd0);
    check("R8 m differs", {28'd0, exc_kind}, 32'd7);
    check("R8 exc_pc", exc_pc, 32'h304);

    // R10 underflow
    step(4'd9, 32'h8, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0);
    wreg(4'd0, 32'h8000_0000);
    step(4'd2, 32'd0, 4'd0, 32'h1230, 1'b0, 4'd0, 32'd0);
    check("R10 fill 8", {28'd0, exc_kind}, 32'd5);
    check("R10 base", {28'd0, win_base}, 32'd1);
    check("R10 owb", {28'd0, st_owb}, 32'd3);
    check("R10 excm", {31'd0, st_excm}, 32'd1);
    check("R10 pc", exc_pc, 32'h1230);
    check("R10 no ret", {31'd0, ret_valid}, 32'd0);
    step(4'd8, 32'h5, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0);
    step(4'd9, 32'h2, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0);
    wreg(4'd0, 32'hC000_0000);
    step(4'd2, 32'd0, 4'd0, 32'h1240, 1'b0, 4'd0, 32'd0);
    check("R10 fill 12", {28'd0, exc_kind}, 32'd6);
    check("R10 wrap base", {28'd0, win_base}, 32'd14);
    check("R10 owb 1", {28'd0, st_owb}, 32'd1);

    // R12 pulse lasts one cycle
    @(posedge clk);
    #1;
    check("R12 pulse end", {31'd0, exc_valid}, 32'd0);
    check("R12 kind idle", {28'd0, exc_kind}, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule